// File: doc/BRIEF.md
# SIMD floating-point control and status register

This block holds the 32-bit control and status word of a SIMD floating-point unit. Software writes the word through a strobed write port and reads it back on a read port. The execution pipeline reports detected arithmetic conditions on a sticky-flag update port. The block drives the live rounding mode, the flush-to-zero enable and the denormals-are-zeros enable to the datapath.

The low six bits collect exception flags. Each flag stays set until software writes a zero to it. Six mask bits, one per flag, decide which reported conditions raise an exception request. The request comes only from a condition that an operation reports. A software write never raises one, even a write that unmasks a condition whose flag is already set.

A write that sets any bit in the upper sixteen reserved bits is rejected. The block pulses a fault output and leaves the register unchanged.

Top module: `simd_fp_csr`

## Requirements
- R1: After reset the register reads 0x0000_1F80: every mask bit (bits 7 to 12) is set, and all flags, bit 6, the rounding field (bits 14:13) and bit 15 are zero. The outputs round_mode, ftz_en, daz_en, wr_fault and exc_req are all zero.
- R2: A write with wr_data[31:16] equal to zero stores wr_data[15:0], and rd_data shows it one cycle later. rd_data[31:16] always reads zero.
- R3: round_mode follows bits 14:13 (00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero), ftz_en follows bit 15 and daz_en follows bit 6.
- R4: A write with any of wr_data[31:16] non-zero raises wr_fault for exactly the one cycle after the write and leaves the whole register unchanged.
- R5: Flags are sticky. For op_valid, op_flags[i] sets register bit i, with bit order 0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision. Bits already set are kept. A flag clears only when a legal write puts a zero in it.
- R6: When a legal write and op_valid occur in the same cycle, the stored value is the write data with op_flags ORed into bits 5:0.
- R7: exc_req is high for the one cycle after an op_valid cycle in which some op_flags[i] is set while mask bit 7+i (as held in that cycle) is clear.
- R8: A write that clears a mask bit whose flag is already set raises no exc_req. Without op_valid, exc_req stays low.
- R9: A reported condition whose mask bit is set updates its flag but raises no exc_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Current register contents |
| op_valid | input | 1 | Datapath condition report valid |
| op_flags | input | 6 | Detected conditions, flag bit order |
| round_mode | output | 2 | Live rounding-control field |
| ftz_en | output | 1 | Flush-to-zero enable |
| daz_en | output | 1 | Denormals-are-zeros enable |
| wr_fault | output | 1 | One-cycle pulse after a rejected write |
| exc_req | output | 1 | One-cycle unmasked exception request |

## Verification
The assertions assume that wr_en, wr_data, op_valid and op_flags are known and stable around each rising edge. They assume that op_flags matters only while op_valid is high. The bench changes every input only on falling edges and returns the strobes to zero between scenarios. Each scenario therefore starts from idle inputs and a register value that the bench has just written itself.

// File: rtl/simd_csr_pkg.sv
package simd_csr_pkg;
    parameter int DATA_W  = 32;
    parameter int CTRL_W  = 16;
    parameter int FLAG_W  = 6;
    parameter int RM_W    = 2;

    localparam int RSVD_W   = DATA_W - CTRL_W;
    localparam int FLAG_LO  = 0;
    localparam int DAZ_BIT  = FLAG_LO + FLAG_W;
    localparam int MASK_LO  = DAZ_BIT + 1;
    localparam int RM_LO    = MASK_LO + FLAG_W;
    localparam int FTZ_BIT  = RM_LO + RM_W;

    localparam logic [CTRL_W-1:0] CTRL_RESET =
        CTRL_W'({FLAG_W{1'b1}}) << MASK_LO;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              fault;
        logic              exc;
    } csr_state_t;
endpackage

// File: rtl/csr_write_check.sv
module csr_write_check
    import simd_csr_pkg::*;
#(
    parameter int W_DATA = DATA_W,
    parameter int W_CTRL = CTRL_W
) (
    input  logic              wr_en,
    input  logic [W_DATA-1:0] wr_data,
    output logic              accept,
    output logic              reject
);
    localparam int W_RSVD = W_DATA - W_CTRL;

    logic rsvd_nonzero;

    always_comb begin
        rsvd_nonzero = |wr_data[W_DATA-1 -: W_RSVD];
        accept       = wr_en && !rsvd_nonzero;
        reject       = wr_en && rsvd_nonzero;
    end
endmodule

// File: rtl/csr_exc_detect.sv
module csr_exc_detect
    import simd_csr_pkg::*;
#(
    parameter int N = FLAG_W
) (
    input  logic         op_valid,
    input  logic [N-1:0] op_flags,
    input  logic [N-1:0] mask,
    output logic         hit
);
    logic [N-1:0] per_cond;

    for (genvar i = 0; i < N; i++) begin : g_cond
        assign per_cond[i] = op_flags[i] & ~mask[i];
    end

    always_comb begin
        hit = op_valid && (|per_cond);
    end
endmodule

// File: rtl/simd_fp_csr.sv
module simd_fp_csr
    import simd_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              op_valid,
    input  logic [FLAG_W-1:0] op_flags,
    output logic [RM_W-1:0]   round_mode,
    output logic              ftz_en,
    output logic              daz_en,
    output logic              wr_fault,
    output logic              exc_req
);
    csr_state_t state_d, state_q;
    logic       wr_accept, wr_reject, exc_hit;

    csr_write_check u_wchk (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .accept  (wr_accept),
        .reject  (wr_reject)
    );

    csr_exc_detect u_exc (
        .op_valid (op_valid),
        .op_flags (op_flags),
        .mask     (state_q.ctrl[MASK_LO +: FLAG_W]),
        .hit      (exc_hit)
    );

    always_comb begin
        state_d = state_q;
        // legal write first, then datapath conditions ORed on top
        if (wr_accept) begin
            state_d.ctrl = wr_data[CTRL_W-1:0];
        end
        if (op_valid) begin
            state_d.ctrl[FLAG_LO +: FLAG_W] =
                state_d.ctrl[FLAG_LO +: FLAG_W] | op_flags;
        end
        state_d.fault = wr_reject;
        state_d.exc   = exc_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.ctrl  <= CTRL_RESET;
            state_q.fault <= 1'b0;
            state_q.exc   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data    = {{RSVD_W{1'b0}}, state_q.ctrl};
    assign round_mode = state_q.ctrl[RM_LO +: RM_W];
    assign ftz_en     = state_q.ctrl[FTZ_BIT];
    assign daz_en     = state_q.ctrl[DAZ_BIT];
    assign wr_fault   = state_q.fault;
    assign exc_req    = state_q.exc;
endmodule

// File: rtl/simd_fp_csr_checker.sv
module simd_fp_csr_checker
    import simd_csr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              op_valid,
    input logic [FLAG_W-1:0] op_flags,
    input logic              wr_fault,
    input logic              exc_req
);
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:CTRL_W] == '0); // R2

    AST_BAD_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && |wr_data[DATA_W-1:CTRL_W]) |=> wr_fault); // R4

    AST_BAD_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && |wr_data[DATA_W-1:CTRL_W] && !op_valid) |=> $stable(rd_data)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ((rd_data[FLAG_W-1:0] & $past(op_flags)) == $past(op_flags))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !op_valid) |=> $stable(rd_data)); // R5

    AST_UNMASKED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && |(op_flags & ~rd_data[MASK_LO +: FLAG_W])) |=> exc_req); // R7

    AST_NO_REQ_WITHOUT_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !exc_req); // R8

    AST_MASKED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((op_flags & ~rd_data[MASK_LO +: FLAG_W]) == '0)) |=> !exc_req); // R9
endmodule

bind simd_fp_csr simd_fp_csr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .op_valid (op_valid),
    .op_flags (op_flags),
    .wr_fault (wr_fault),
    .exc_req  (exc_req)
);

// File: tb/simd_fp_csr_bench.sv
`timescale 1ns/1ps
module simd_fp_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_valid = 1'b0;
    logic [5:0]  op_flags = '0;
    logic [31:0] rd_data;
    logic [1:0]  round_mode;
    logic        ftz_en, daz_en, wr_fault, exc_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    simd_fp_csr u_simd_fp_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .op_valid(op_valid), .op_flags(op_flags),
        .round_mode(round_mode), .ftz_en(ftz_en), .daz_en(daz_en),
        .wr_fault(wr_fault), .exc_req(exc_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; outputs are then read at the following falling edge
    task automatic cycle(input logic we, input logic [31:0] wd, input logic ov, input logic [5:0] of);
        @(negedge clk);
        wr_en = we; wr_data = wd; op_valid = ov; op_flags = of;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; op_valid = 1'b0; op_flags = '0;
    endtask

    task automatic t_reset();
        check("R1 rd_data", rd_data, 32'h0000_1F80);
        check("R1 round_mode", 32'(round_mode), 0);
        check("R1 ftz_en", 32'(ftz_en), 0);
        check("R1 daz_en", 32'(daz_en), 0);
        check("R1 wr_fault", 32'(wr_fault), 0);
        check("R1 exc_req", 32'(exc_req), 0);
    endtask

    task automatic t_legal_write();
        cycle(1, 32'h0000_E040, 0, 0);
        check("R2 stored", rd_data, 32'h0000_E040);
        check("R3 round_mode 11", 32'(round_mode), 3);
        check("R3 ftz_en", 32'(ftz_en), 1);
        check("R3 daz_en", 32'(daz_en), 1);
        cycle(1, 32'h0000_3F80, 0, 0);
        check("R3 round_mode 01", 32'(round_mode), 1);
        check("R3 ftz off", 32'(ftz_en), 0);
        check("R2 stored 2", rd_data, 32'h0000_3F80);
    endtask

    task automatic t_bad_write();
        cycle(1, 32'h0001_0000, 0, 0);
        check("R4 fault pulse", 32'(wr_fault), 1);
        check("R4 unchanged", rd_data, 32'h0000_3F80);
        cycle(1, 32'h8000_0000, 0, 0);
        check("R4 fault high bit", 32'(wr_fault), 1);
        check("R4 unchanged 2", rd_data, 32'h0000_3F80);
        @(negedge clk);
        check("R4 fault one cycle", 32'(wr_fault), 0);
    endtask

    task automatic t_sticky();
        cycle(1, 32'h0000_1F80, 0, 0);
        cycle(0, 0, 1, 6'b000101);
        check("R5 flags set", rd_data, 32'h0000_1F85);
        check("R9 masked no req", 32'(exc_req), 0);
        cycle(0, 0, 1, 6'b001000);
        check("R5 flags accumulate", rd_data, 32'h0000_1F8D);
        @(negedge clk);
        check("R5 flags hold", rd_data, 32'h0000_1F8D);
        cycle(1, 32'h0000_1F88, 0, 0);
        check("R5 cleared by write zero", rd_data, 32'h0000_1F88);
    endtask

    task automatic t_same_cycle();
        cycle(1, 32'h0000_1F82, 1, 6'b010000);
        check("R6 write then or", rd_data, 32'h0000_1F92);
    endtask

    task automatic t_unmask();
        cycle(1, 32'h0000_1F84, 0, 0);
        cycle(1, 32'h0000_1D84, 0, 0);
        check("R8 no req on unmask", 32'(exc_req), 0);
        @(negedge clk);
        check("R8 still no req", 32'(exc_req), 0);
        cycle(0, 0, 1, 6'b000100);
        check("R7 req on report", 32'(exc_req), 1);
        @(negedge clk);
        check("R7 req one cycle", 32'(exc_req), 0);
        cycle(0, 0, 1, 6'b000001);
        check("R9 masked other", 32'(exc_req), 0);
        check("R9 flag set", rd_data, 32'h0000_1D85);
    endtask

    task automatic t_mask_order();
        for (int i = 0; i < 6; i++) begin
            logic [31:0] w;
            w = 32'h0000_1F80 & ~(32'h1 << (7 + i));
            cycle(1, w, 0, 0);
            cycle(0, 0, 1, 6'(1 << i));
            check($sformatf("R7 bit %0d unmasked", i), 32'(exc_req), 1);
            cycle(0, 0, 1, 6'(1 << ((i + 1) % 6)));
            check($sformatf("R9 bit %0d masked", (i + 1) % 6), 32'(exc_req), 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legal_write();
        t_bad_write();
        t_sticky();
        t_same_cycle();
        t_unmask();
        t_mask_order();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule